// File: doc/BRIEF.md
# UART FIFO Control and Interrupt Identification Unit

This unit is the register-side control for a UART whose transmit and receive FIFOs have a depth set by a parameter. It sits behind a single 16-bit location that does two jobs. A write to it sets the FIFO control fields: the enable, the two threshold selectors, the DMA signalling mode and two self-clearing reset bits. A read from it returns the identity of the most urgent pending interrupt, together with a FIFO-enabled indication.

The unit does not hold the FIFO storage. It sees each FIFO only as an occupancy count and drives one-cycle reset pulses back to it. From the counts and the selected thresholds it forms two level flags. The receive flag stops the remote sender, by de-asserting RTS, and raises the receive DMA request. The transmit flag raises the transmit-empty interrupt and the transmit DMA request. Three more inputs report line-status errors, character timeouts and busy conditions, and these take part in the interrupt priority.

Every output is registered. Each output reflects the inputs and the stored settings of the cycle before.

Top module: `uart_fifo_ctl_irq`

## Requirements
- R1: While reset is asserted and in the cycle after it, `rd_data` is 0x0001, `irq`, both reset pulses and both level flags are 0, and both DMA request outputs are 1.
- R2: With the FIFOs enabled, `rx_level_hit` is 1 when `rx_count` is at least the receive trigger chosen by write bits 7:6. The encodings are 00 for one entry, 01 for DEPTH/4, 10 for DEPTH/2 and 11 for DEPTH-2.
- R3: With the FIFOs enabled, `tx_level_hit` is 1 when `tx_count` is at most the threshold chosen by write bits 5:4. The encodings are 00 for zero, 01 for two, 10 for DEPTH/4 and 11 for DEPTH/2.
- R4: With the FIFOs disabled (write bit 0 = 0), the selectors have no effect. The receive trigger is one entry and the transmit threshold is zero.
- R5: A write with bit 2 set gives exactly one cycle of `tx_fifo_rst`, in the cycle after the write. Bit 1 does the same for `rx_fifo_rst`. Neither bit stays set.
- R6: A write whose bit 0 differs from the stored enable pulses both FIFO resets for one cycle. A write that keeps bit 0 and has bits 2:1 clear pulses neither.
- R7: Read bits 7:6 are 11 when the FIFOs are enabled and 00 when they are disabled. Bits 15:8 and 5:4 read zero.
- R8: Read bits 3:0 give the interrupt ID of the highest-priority source. In priority order these are: line error 0110, receive level 0100, character timeout 1100, transmit level 0010 and busy 0111. The value 0001 means no source is pending.
- R9: `irq` is 1 exactly when read bits 3:0 are not 0001.
- R10: The DMA requests are active low. When write bit 3 = 0, the receive request is active while `rx_count` is nonzero, and the transmit request is active while `tx_count` is zero. When write bit 3 = 1, the requests follow `rx_level_hit` and `tx_level_hit`.
- R11: A control write changes the read value two cycles after the write cycle: the first cycle stores it and the second registers the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the control fields |
| wr_data | input | 16 | Write data: bits 7:6 receive trigger, 5:4 transmit threshold, 3 DMA mode, 2 transmit reset, 1 receive reset, 0 enable |
| rd_data | output | 16 | Read value: enabled indication in bits 7:6, interrupt ID in bits 3:0 |
| rx_count | input | CW | Receive FIFO occupancy |
| tx_count | input | CW | Transmit FIFO occupancy |
| line_err | input | 1 | Receiver line-status condition pending |
| char_timeout | input | 1 | Character timeout pending |
| busy_det | input | 1 | Busy condition pending |
| irq | output | 1 | Interrupt request |
| tx_fifo_rst | output | 1 | One-cycle transmit FIFO control reset |
| rx_fifo_rst | output | 1 | One-cycle receive FIFO control reset |
| rx_level_hit | output | 1 | Receive trigger reached (drives RTS de-assertion) |
| tx_level_hit | output | 1 | Transmit occupancy at or below threshold |
| dma_rx_req_n | output | 1 | Receive DMA request, active low |
| dma_tx_req_n | output | 1 | Transmit DMA request, active low |

## Verification
The assertions are checked on every cycle. They cover the following:
- A reset pulse only ever follows a write cycle.
- An enable toggle always pulses both resets.
- A line error always wins the identification.
- An empty receive FIFO never reaches its trigger.
- A transmit FIFO above half full never meets its threshold.
- The interrupt output agrees with the read ID.
- The enabled bits mirror the written enable two cycles later.

Only the bench scenarios can show the following:
- The exact threshold values for each selector encoding, with the FIFOs both enabled and disabled.
- The full priority order among overlapping sources.
- The DMA behaviour in both modes.
- That a reset pulse lasts one cycle and is absent after a write that changes nothing.

// File: rtl/uart_fcr_pkg.sv
package uart_fcr_pkg;

  typedef enum logic [3:0] {
    IID_NONE = 4'h1,
    IID_THRE = 4'h2,
    IID_RDA  = 4'h4,
    IID_RLS  = 4'h6,
    IID_BUSY = 4'h7,
    IID_CTO  = 4'hC
  } iid_e;

  typedef struct packed {
    logic       fifo_on;
    logic [1:0] rx_sel;
    logic [1:0] tx_sel;
    logic       dma_mode;
  } fcr_cfg_t;

endpackage

// File: rtl/fcr_ctl_reg.sv
module fcr_ctl_reg
  import uart_fcr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic [7:0] wr_bits,
  output fcr_cfg_t   cfg,
  output logic       tx_rst_pulse,
  output logic       rx_rst_pulse
);

  logic en_flip;
  assign en_flip = wr_bits[0] ^ cfg.fifo_on;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg          <= '0;
      tx_rst_pulse <= 1'b0;
      rx_rst_pulse <= 1'b0;
    end else begin
      tx_rst_pulse <= 1'b0;
      rx_rst_pulse <= 1'b0;
      if (wr_en) begin
        cfg.fifo_on  <= wr_bits[0];
        cfg.rx_sel   <= wr_bits[7:6];
        cfg.tx_sel   <= wr_bits[5:4];
        cfg.dma_mode <= wr_bits[3];
        tx_rst_pulse <= wr_bits[2] | en_flip;
        rx_rst_pulse <= wr_bits[1] | en_flip;
      end
    end
  end

  // R5: reset pulses only arise from a write in the previous cycle
  p_pulse_from_write_r5: assert property (@(posedge clk) disable iff (rst)
    (tx_rst_pulse || rx_rst_pulse) |-> $past(wr_en));

  // R6: a toggle of the enable resets both FIFOs
  p_toggle_both_r6: assert property (@(posedge clk) disable iff (rst)
    $past(wr_en && (wr_bits[0] != cfg.fifo_on)) |-> (tx_rst_pulse && rx_rst_pulse));

endmodule

// File: rtl/fcr_level.sv
module fcr_level
  import uart_fcr_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CW    = $clog2(DEPTH + 1),
  parameter bit IS_RX = 1'b1
) (
  input  fcr_cfg_t        cfg,
  input  logic [CW-1:0]   count,
  output logic            hit
);

  localparam logic [CW-1:0] QTR  = CW'(DEPTH / 4);
  localparam logic [CW-1:0] HALF = CW'(DEPTH / 2);
  localparam logic [CW-1:0] NEAR = CW'(DEPTH - 2);
  localparam logic [CW-1:0] ONE  = CW'(1);
  localparam logic [CW-1:0] TWO  = CW'(2);

  logic [CW-1:0] limit;

  generate
    if (IS_RX) begin : g_rx
      always_comb begin
        if (!cfg.fifo_on) limit = ONE;
        else begin
          unique case (cfg.rx_sel)
            2'd0: limit = ONE;
            2'd1: limit = QTR;
            2'd2: limit = HALF;
            default: limit = NEAR;
          endcase
        end
      end
      assign hit = (count >= limit);
    end else begin : g_tx
      always_comb begin
        if (!cfg.fifo_on) limit = '0;
        else begin
          unique case (cfg.tx_sel)
            2'd0: limit = '0;
            2'd1: limit = TWO;
            2'd2: limit = QTR;
            default: limit = HALF;
          endcase
        end
      end
      assign hit = (count <= limit);
    end
  endgenerate

endmodule

// File: rtl/fcr_irq_prio.sv
module fcr_irq_prio
  import uart_fcr_pkg::*;
(
  input  logic line_err,
  input  logic rx_hit,
  input  logic char_timeout,
  input  logic tx_hit,
  input  logic busy_det,
  output iid_e id
);

  always_comb begin
    if (line_err)          id = IID_RLS;
    else if (rx_hit)       id = IID_RDA;
    else if (char_timeout) id = IID_CTO;
    else if (tx_hit)       id = IID_THRE;
    else if (busy_det)     id = IID_BUSY;
    else                   id = IID_NONE;
  end

endmodule

// File: rtl/uart_fifo_ctl_irq.sv
module uart_fifo_ctl_irq
  import uart_fcr_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [15:0]   wr_data,
  output logic [15:0]   rd_data,
  input  logic [CW-1:0] rx_count,
  input  logic [CW-1:0] tx_count,
  input  logic          line_err,
  input  logic          char_timeout,
  input  logic          busy_det,
  output logic          irq,
  output logic          tx_fifo_rst,
  output logic          rx_fifo_rst,
  output logic          rx_level_hit,
  output logic          tx_level_hit,
  output logic          dma_rx_req_n,
  output logic          dma_tx_req_n
);

  fcr_cfg_t cfg;
  logic     rx_hit_c, tx_hit_c;
  iid_e     id_c;
  logic     rx_req_c, tx_req_c;

  fcr_ctl_reg u_ctl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_bits(wr_data[7:0]),
    .cfg(cfg), .tx_rst_pulse(tx_fifo_rst), .rx_rst_pulse(rx_fifo_rst)
  );

  fcr_level #(.DEPTH(DEPTH), .CW(CW), .IS_RX(1'b1)) u_rx_lvl (
    .cfg(cfg), .count(rx_count), .hit(rx_hit_c)
  );

  fcr_level #(.DEPTH(DEPTH), .CW(CW), .IS_RX(1'b0)) u_tx_lvl (
    .cfg(cfg), .count(tx_count), .hit(tx_hit_c)
  );

  fcr_irq_prio u_prio (
    .line_err(line_err), .rx_hit(rx_hit_c), .char_timeout(char_timeout),
    .tx_hit(tx_hit_c), .busy_det(busy_det), .id(id_c)
  );

  always_comb begin
    if (cfg.dma_mode) begin
      rx_req_c = rx_hit_c;
      tx_req_c = tx_hit_c;
    end else begin
      rx_req_c = (rx_count != '0);
      tx_req_c = (tx_count == '0);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data      <= 16'h0001;
      irq          <= 1'b0;
      rx_level_hit <= 1'b0;
      tx_level_hit <= 1'b0;
      dma_rx_req_n <= 1'b1;
      dma_tx_req_n <= 1'b1;
    end else begin
      rd_data      <= {8'h00, {2{cfg.fifo_on}}, 2'b00, id_c};
      irq          <= (id_c != IID_NONE);
      rx_level_hit <= rx_hit_c;
      tx_level_hit <= tx_hit_c;
      dma_rx_req_n <= ~rx_req_c;
      dma_tx_req_n <= ~tx_req_c;
    end
  end

  // R8: a line error always takes the identification
  p_line_wins_r8: assert property (@(posedge clk) disable iff (rst)
    $past(line_err) |-> (rd_data[3:0] == 4'h6));

  // R9: interrupt output agrees with the read ID
  p_irq_id_r9: assert property (@(posedge clk) disable iff (rst)
    irq == (rd_data[3:0] != 4'h1));

  // R2: an empty receive FIFO never reaches any trigger
  p_empty_rx_r2: assert property (@(posedge clk) disable iff (rst)
    $past(rx_count == '0) |-> !rx_level_hit);

  // R3: above half full never meets a transmit threshold
  p_tx_high_r3: assert property (@(posedge clk) disable iff (rst)
    $past(tx_count > CW'(DEPTH / 2)) |-> !tx_level_hit);

  // R7 / R11: enabled indication follows the written enable two cycles on
  p_fe_mirror_r7: assert property (@(posedge clk) disable iff (rst)
    $past(wr_en, 2) |-> (rd_data[7:6] == {2{$past(wr_data[0], 2)}}));

endmodule

// File: tb/uart_fifo_ctl_irq_tb_top.sv
`timescale 1ns/1ps
module uart_fifo_ctl_irq_tb_top;

  localparam int DEPTH = 8;
  localparam int CW    = $clog2(DEPTH + 1);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [15:0]   wr_data = '0;
  logic [15:0]   rd_data;
  logic [CW-1:0] rx_count = '0;
  logic [CW-1:0] tx_count = '0;
  logic          line_err = 1'b0, char_timeout = 1'b0, busy_det = 1'b0;
  logic          irq, tx_fifo_rst, rx_fifo_rst, rx_level_hit, tx_level_hit;
  logic          dma_rx_req_n, dma_tx_req_n;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  uart_fifo_ctl_irq #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .rx_count(rx_count), .tx_count(tx_count), .line_err(line_err),
    .char_timeout(char_timeout), .busy_det(busy_det), .irq(irq),
    .tx_fifo_rst(tx_fifo_rst), .rx_fifo_rst(rx_fifo_rst),
    .rx_level_hit(rx_level_hit), .tx_level_hit(tx_level_hit),
    .dma_rx_req_n(dma_rx_req_n), .dma_tx_req_n(dma_tx_req_n)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  function automatic int rx_trig(input int en, input int sel);
    if (en == 0) return 1;
    case (sel)
      0: return 1;
      1: return DEPTH / 4;
      2: return DEPTH / 2;
      default: return DEPTH - 2;
    endcase
  endfunction

  function automatic int tx_thr(input int en, input int sel);
    if (en == 0) return 0;
    case (sel)
      0: return 0;
      1: return 2;
      2: return DEPTH / 4;
      default: return DEPTH / 2;
    endcase
  endfunction

  initial begin
    #(4 * 150000);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 rd", rd_data, 16'h0001);
    chk("R1 irq", {15'b0, irq}, 16'h0);
    chk("R1 pulses", {14'b0, tx_fifo_rst, rx_fifo_rst}, 16'h0);
    chk("R1 flags", {14'b0, rx_level_hit, tx_level_hit}, 16'h0);
    chk("R1 dma", {14'b0, dma_rx_req_n, dma_tx_req_n}, 16'h3);
    rst = 1'b0;

    // R5: transmit reset bit, one cycle only
    wr(16'h0004);
    chk("R5 tx pulse", {14'b0, tx_fifo_rst, rx_fifo_rst}, 16'h2);
    @(negedge clk);
    chk("R5 tx self-clear", {14'b0, tx_fifo_rst, rx_fifo_rst}, 16'h0);
    wr(16'h0002);
    chk("R5 rx pulse", {14'b0, tx_fifo_rst, rx_fifo_rst}, 16'h1);
    @(negedge clk);
    chk("R5 rx self-clear", {14'b0, tx_fifo_rst, rx_fifo_rst}, 16'h0);

    // R6 / R11 / R7: enable toggle pulses both; read bits lag two cycles
    wr(16'h0001);
    chk("R6 toggle on", {14'b0, tx_fifo_rst, rx_fifo_rst}, 16'h3);
    chk("R11 not yet", {14'b0, rd_data[7:6]}, 16'h0);
    @(negedge clk);
    chk("R7 enabled bits", rd_data & 16'hFFF0, 16'h00C0);
    wr(16'h00F1);
    chk("R6 same value", {14'b0, tx_fifo_rst, rx_fifo_rst}, 16'h0);
    wr(16'h0000);
    chk("R6 toggle off", {14'b0, tx_fifo_rst, rx_fifo_rst}, 16'h3);
    @(negedge clk);
    chk("R7 disabled bits", rd_data & 16'hFFF0, 16'h0000);

    // Sweep of settings and occupancies
    for (int en = 0; en < 2; en++)
      for (int rs = 0; rs < 4; rs++)
        for (int ts = 0; ts < 4; ts++)
          for (int dm = 0; dm < 2; dm++) begin
            wr(16'(rs * 64 + ts * 16 + dm * 8 + en));
            for (int rc = 0; rc <= DEPTH; rc++)
              for (int tc = 0; tc <= DEPTH; tc++) begin
                int s, rh, th, id, exp_rx_n, exp_tx_n;
                s = (rc + 2 * tc + rs + 3 * ts) % 8;
                @(negedge clk);
                rx_count = CW'(rc); tx_count = CW'(tc);
                line_err = (s == 7); char_timeout = s[0]; busy_det = s[1];
                rh = (rc >= rx_trig(en, rs)) ? 1 : 0;
                th = (tc <= tx_thr(en, ts)) ? 1 : 0;
                if (s == 7) id = 6;
                else if (rh == 1) id = 4;
                else if (s[0]) id = 12;
                else if (th == 1) id = 2;
                else if (s[1]) id = 7;
                else id = 1;
                if (dm == 1) begin
                  exp_rx_n = 1 - rh; exp_tx_n = 1 - th;
                end else begin
                  exp_rx_n = (rc != 0) ? 0 : 1; exp_tx_n = (tc == 0) ? 0 : 1;
                end
                @(negedge clk);
                chk(en == 1 ? "R2 rx level" : "R4 rx level", {15'b0, rx_level_hit}, 16'(rh));
                chk(en == 1 ? "R3 tx level" : "R4 tx level", {15'b0, tx_level_hit}, 16'(th));
                chk("R8 R7 read value", rd_data, 16'((en == 1 ? 192 : 0) + id));
                chk("R9 irq", {15'b0, irq}, 16'(id != 1));
                chk("R10 dma", {14'b0, dma_rx_req_n, dma_tx_req_n}, 16'(exp_rx_n * 2 + exp_tx_n));
              end
          end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule